// File: doc/BRIEF.md
# Configurable Decimated SAD Unit

This block measures how closely a candidate 4x4 reference block matches a 4x4 block of original pixels, as one step of motion estimation. Both blocks arrive side by side as sixteen unsigned 8-bit pixels each, together with a sampling mode. The block then returns one unsigned sum of absolute differences. In full mode it sums all sixteen positions. The two decimated modes sum a fixed checkerboard half of the positions, or one position out of each 2x2 quad. Decimated sums are not scaled back up, so their range is smaller.

The mode comes with each block, so blocks in different modes can follow one another at full rate. Positions the current mode does not use do not load their operand registers, and so do not toggle. The pixel at position p (row r, column c, p = 4r + c) sits in bits [8p+7:8p] of each pixel bus.

Both ends of the block use valid/ready handshakes. A block is taken on a rising edge where `in_valid` and `in_ready` are both high. A result leaves on a rising edge where `out_valid` and `out_ready` are both high. The pipeline moves forward only while its output register is empty or being drained. When `out_valid` is high and `out_ready` is low, the whole pipeline freezes and `in_ready` drops. No accepted block is lost, duplicated or reordered.

Top module: `sad_decim_top`

## Requirements
- R1: With mode 2'b00, the result is the sum over all 16 positions of |orig - ref|.
- R2: With mode 2'b01, the result sums only the positions whose row + column is even (8 positions, checkerboard).
- R3: With mode 2'b10, the result sums only the positions whose row and column are both even (4 positions).
- R4: Mode 2'b11 gives the same result as mode 2'b00.
- R5: Pixel values at positions the current mode does not use have no effect on the result. The operand registers of those positions keep their previous contents.
- R6: Results are not rescaled. The largest full-mode result, 4080, is returned exactly on the 12-bit output.
- R7: When `out_ready` stays high, the result of a block accepted on rising edge k is presented with `out_valid` high after rising edge k+2, the third edge counting the accepting one. A new block can be accepted on every cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sad` hold their values and `in_ready` is low. Results leave in the order their blocks were accepted.
- R9: A synchronous active-high reset clears `out_valid` and all pipeline valid state, drops in-flight blocks, and leaves `in_ready` high.
- R10: The mode is taken with each block, so back-to-back blocks in different modes each use their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can be accepted this cycle |
| in_mode | input | 2 | Sampling mode: 00 full, 01 checkerboard half, 10 quarter, 11 full |
| in_orig | input | 128 | Original pixels, position p in bits [8p+7:8p] |
| in_ref | input | 128 | Reference pixels, same layout |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_sad | output | 12 | Sum of absolute differences |

## Verification
The bench sends blocks whose unused positions differ wildly while their used positions match exactly, so the correct result is zero. A mask that is wrong, or that is rotated by one position, would then give a nonzero sum. All-255 against all-0 blocks in every mode give the exact expected sums (4080, 2040 and 1020), which exposes a truncated adder tree or a result that is rescaled. Back-to-back blocks that change mode on every cycle catch a mode that is read at the wrong pipeline stage and applied to the next block. Random stalls on `out_ready` show up any result that changes, is dropped or is repeated while the pipeline is frozen. A reset in the middle of a stream must leave no stale valid result behind.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_QUARTER = 2'b10,
    MODE_FULL_B  = 2'b11
  } sad_mode_e;

endpackage

// File: rtl/sad_pos_select.sv
module sad_pos_select #(
  parameter int DIM = 4
) (
  input  logic [1:0]         mode,
  output logic [DIM*DIM-1:0] sel
);
  import sad_pkg::*;

  // One select bit per pixel position, decoded from the mode.
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      localparam bit ON_CHECKER = (((r + c) % 2) == 0);
      localparam bit ON_QUARTER = ((r % 2) == 0) && ((c % 2) == 0);
      assign sel[r*DIM+c] = (mode == MODE_HALF)    ? ON_CHECKER :
                            (mode == MODE_QUARTER) ? ON_QUARTER : 1'b1;
    end
  end

endmodule

// File: rtl/sad_lane.sv
module sad_lane #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_op,
  input  logic             load_ad,
  input  logic [PIX_W-1:0] orig_i,
  input  logic [PIX_W-1:0] ref_i,
  output logic [PIX_W-1:0] absd_o
);
  logic [PIX_W-1:0] a_q, b_q, ad_q;

  // Operand stage: loads only when this position is in use.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_op) begin
      a_q <= orig_i;
      b_q <= ref_i;
    end
  end

  // Absolute-difference stage.
  always_ff @(posedge clk) begin
    if (rst)
      ad_q <= '0;
    else if (load_ad)
      ad_q <= (a_q > b_q) ? (a_q - b_q) : (b_q - a_q);
  end

  assign absd_o = ad_q;

  AST_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !load_op |=> ($stable(a_q) && $stable(b_q))); // R5

  AST_ABSD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_ad |=> $stable(ad_q)); // R5

endmodule

// File: rtl/sad_adder_tree.sv
module sad_adder_tree #(
  parameter int N = 16,
  parameter int W = 12
) (
  input  logic [N*W-1:0] leaves,
  output logic [W-1:0]   sum
);
  localparam int NODES = 2 * N - 1;

  // Heap-ordered tree: node i sums children 2i+1 and 2i+2, leaves sit at N-1..2N-2.
  logic [W-1:0] node [NODES];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign node[N-1+i] = leaves[i*W +: W];
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_inner
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum = node[0];

endmodule

// File: rtl/sad_decim_top.sv
module sad_decim_top #(
  parameter  int PIX_W = 8,
  parameter  int DIM   = 4,
  localparam int NPOS  = DIM * DIM,
  localparam int SUM_W = PIX_W + $clog2(NPOS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_mode,
  input  logic [NPOS*PIX_W-1:0] in_orig,
  input  logic [NPOS*PIX_W-1:0] in_ref,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SUM_W-1:0]      out_sad
);
  localparam int N_HALF  = (NPOS + 1) / 2;
  localparam int N_QTR   = ((DIM + 1) / 2) * ((DIM + 1) / 2);
  localparam int SAD_MAX = NPOS * ((1 << PIX_W) - 1);

  // Global advance: the pipeline moves only when the output slot can change.
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic            v_s1, v_s2;
  logic [1:0]      mode_s1;
  logic [NPOS-1:0] sel_in, sel_s1, sel_s2;

  sad_pos_select #(.DIM(DIM)) u_sel_in (.mode(in_mode), .sel(sel_in));
  sad_pos_select #(.DIM(DIM)) u_sel_s1 (.mode(mode_s1), .sel(sel_s1));

  always_ff @(posedge clk) begin
    if (rst) begin
      v_s1      <= 1'b0;
      v_s2      <= 1'b0;
      out_valid <= 1'b0;
      mode_s1   <= 2'b00;
      sel_s2    <= '0;
    end else if (adv) begin
      v_s1      <= in_valid;
      v_s2      <= v_s1;
      out_valid <= v_s2;
      if (in_valid) mode_s1 <= in_mode;
      if (v_s1)     sel_s2  <= sel_s1;
    end
  end

  // Per-position lanes.
  logic [NPOS*SUM_W-1:0] leaf;

  for (genvar i = 0; i < NPOS; i++) begin : g_lane
    logic [PIX_W-1:0] absd;
    sad_lane #(.PIX_W(PIX_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .load_op (adv && in_valid && sel_in[i]),
      .load_ad (adv && v_s1 && sel_s1[i]),
      .orig_i  (in_orig[i*PIX_W +: PIX_W]),
      .ref_i   (in_ref[i*PIX_W +: PIX_W]),
      .absd_o  (absd)
    );
    assign leaf[i*SUM_W +: SUM_W] =
      sel_s2[i] ? {{(SUM_W-PIX_W){1'b0}}, absd} : '0;
  end

  logic [SUM_W-1:0] tree_sum;

  sad_adder_tree #(.N(NPOS), .W(SUM_W)) u_tree (
    .leaves (leaf),
    .sum    (tree_sum)
  );

  always_ff @(posedge clk) begin
    if (rst)
      out_sad <= '0;
    else if (adv && v_s2)
      out_sad <= tree_sum;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sad))); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !v_s1 && !v_s2)); // R9

  AST_MASK_COUNT: assert property (@(posedge clk) disable iff (rst)
    v_s2 |-> (($countones(sel_s2) == NPOS) || ($countones(sel_s2) == N_HALF) ||
              ($countones(sel_s2) == N_QTR))); // R2

  AST_SAD_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_sad) <= SAD_MAX)); // R6

endmodule

// File: tb/sad_decim_top_tb.sv
module sad_decim_top_tb;
  localparam int PIX_W = 8;
  localparam int DIM   = 4;
  localparam int NPOS  = DIM * DIM;
  localparam int SUM_W = 12;
  localparam int BW    = NPOS * PIX_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst;
  logic             in_valid, in_ready, out_valid, out_ready;
  logic [1:0]       in_mode;
  logic [BW-1:0]    in_orig, in_ref;
  logic [SUM_W-1:0] out_sad;

  sad_decim_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_orig(in_orig), .in_ref(in_ref),
    .out_valid(out_valid), .out_ready(out_ready), .out_sad(out_sad)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0, last_stall = -1;
  int    exp_q[$];
  int    push_q[$];
  string tag_q[$];

  function automatic int model_sad(logic [BW-1:0] o, logic [BW-1:0] r, logic [1:0] m);
    int s = 0;
    for (int p = 0; p < NPOS; p++) begin
      int row = p / DIM;
      int col = p % DIM;
      bit use_it;
      int a, b;
      if (m == 2'b01)      use_it = ((row + col) % 2) == 0;
      else if (m == 2'b10) use_it = (row % 2 == 0) && (col % 2 == 0);
      else                 use_it = 1'b1;
      a = int'(o[p*PIX_W +: PIX_W]);
      b = int'(r[p*PIX_W +: PIX_W]);
      if (use_it) s += (a > b) ? a - b : b - a;
    end
    return s;
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00:   return "R1 R10";
      2'b01:   return "R2 R10";
      2'b10:   return "R3 R10";
      default: return "R4 R10";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic observe();
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected out_valid", 1, 0);
      end else begin
        check(tag_q[0], int'(out_sad), exp_q[0]);
        if (last_stall < push_q[0]) check("R7 latency", cyc - push_q[0], 3);
      end
    end else if (exp_q.size() != 0 && last_stall < push_q[0] && cyc - push_q[0] >= 3) begin
      check("R7 missing result", 0, 1);
    end
  endtask

  task automatic step(logic v, logic [1:0] m, logic [BW-1:0] o, logic [BW-1:0] r,
                      logic rdy, string tag);
    @(negedge clk);
    cyc++;
    observe();
    in_valid  = v;
    in_mode   = m;
    in_orig   = o;
    in_ref    = r;
    out_ready = rdy;
    #1;
    if (out_valid && !out_ready) begin
      last_stall = cyc;
      check("R8 in_ready low while stalled", int'(in_ready), 0);
    end
    if (out_valid && out_ready && exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      void'(push_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model_sad(o, r, m));
      push_q.push_back(cyc);
      tag_q.push_back(tag);
    end
  endtask

  function automatic logic [BW-1:0] rand_blk();
    logic [BW-1:0] v;
    for (int p = 0; p < NPOS; p++) v[p*PIX_W +: PIX_W] = 8'($urandom);
    return v;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [BW-1:0] ones, zeros;
    ones  = '1;
    zeros = '0;
    rst = 1'b1; in_valid = 1'b0; in_mode = 2'b00;
    in_orig = '0; in_ref = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R9 in_ready after reset", int'(in_ready), 1);

    // R6: extreme values in every mode, no rescaling.
    step(1, 2'b00, ones, zeros, 1, "R6 R1 full 4080");
    step(1, 2'b01, ones, zeros, 1, "R6 R2 half 2040");
    step(1, 2'b10, ones, zeros, 1, "R6 R3 quarter 1020");
    step(1, 2'b11, zeros, ones, 1, "R4 R6 alt full 4080");
    for (int i = 0; i < 5; i++) step(0, 2'b00, zeros, zeros, 1, "idle");

    // R5: used positions equal, unused positions random -> expected 0.
    for (int i = 0; i < 24; i++) begin
      logic [BW-1:0] o, r;
      logic [1:0] m;
      m = (i % 2 == 0) ? 2'b10 : 2'b01;
      o = rand_blk();
      r = rand_blk();
      for (int p = 0; p < NPOS; p++) begin
        int row = p / DIM;
        int col = p % DIM;
        bit used = (m == 2'b01) ? (((row + col) % 2) == 0)
                                : ((row % 2 == 0) && (col % 2 == 0));
        if (used) r[p*PIX_W +: PIX_W] = o[p*PIX_W +: PIX_W];
      end
      step(1, m, o, r, 1, "R5 unused positions ignored");
    end

    // R1-R4, R7, R10: back-to-back random blocks, mode changes every cycle.
    for (int i = 0; i < 300; i++) begin
      logic [1:0] m;
      m = 2'($urandom);
      step(1, m, rand_blk(), rand_blk(), 1, mode_tag(m));
    end
    for (int i = 0; i < 5; i++) step(0, 2'b00, zeros, zeros, 1, "idle");

    // R8: random valid and random back-pressure.
    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      m = 2'($urandom);
      step(1'($urandom), m, rand_blk(), rand_blk(), ($urandom % 3) != 0, "R8 stream under stall");
    end
    for (int i = 0; i < 8; i++) step(0, 2'b00, zeros, zeros, 1, "idle");
    check("R8 all results delivered", exp_q.size(), 0);

    // R9: reset with blocks in flight.
    step(1, 2'b00, rand_blk(), rand_blk(), 0, "R9 flushed");
    step(1, 2'b01, rand_blk(), rand_blk(), 0, "R9 flushed");
    step(1, 2'b10, rand_blk(), rand_blk(), 0, "R9 flushed");
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    push_q.delete();
    tag_q.delete();
    #1;
    check("R9 out_valid after mid-stream reset", int'(out_valid), 0);
    check("R9 in_ready after mid-stream reset", int'(in_ready), 1);
    for (int i = 0; i < 5; i++) step(0, 2'b00, zeros, zeros, 1, "idle");
    step(1, 2'b00, ones, zeros, 1, "R9 R1 after reset");
    for (int i = 0; i < 5; i++) step(0, 2'b00, zeros, zeros, 1, "idle");
    check("R9 result after reset delivered", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule